// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Pin Mode Decoding

A synthesizable cycle-based model of a byte-wide one-time-programmable memory together with the decoding of its control pins. From an active-low chip enable, an output-enable line, a flag that marks the output-enable pin as raised to programming voltage and a flag that marks the identify line as raised to its high voltage, the block selects one of read, program verify, output disable, standby, program, program inhibit or identifier readout. Its data bus is modelled as an 8-bit value plus a drive-enable that stands for the tri-state control.

Every cell powers up (after reset) in the erased all-ones state. A program pulse can only clear bits: the addressed byte becomes the AND of its old contents and the data pins. The three access delays (address, chip enable, output enable) and the output float delay are expressed as clock-cycle counts. With the identify flag raised, the bus returns fixed identifier bytes chosen by address bit 0 instead of array contents.

Top module: `otp_rom`

## Requirements
- R1: `dout_en` is high only if, at the edge that last updated it, `ce_n`=0, `oe_n`=0 and `vpp_hi`=0 held (or the float hold of R11 is running); output disable (`ce_n`=0, `oe_n`=1) and program (`ce_n`=0, `vpp_hi`=1) never drive the bus beyond that hold.
- R2: With `ce_n`=1 the bus floats (`dout_en`=0) after the float hold, whatever `oe_n` is.
- R3: After reset every byte reads 0xFF and `dout_en` is 0.
- R4: A program write happens once per chip-enable pulse: at the first edge where `ce_n`=0 while `vpp_hi`=1 (with `ce_n`=1 at the edge before), the byte at `addr` becomes old & `din`; data changes later in the same pulse are not written.
- R5: With `vpp_hi`=1 and `ce_n`=1 (inhibit) no byte changes, whatever `din` and `addr` are.
- R6: In read or verify mode (`ce_n`=0, `oe_n`=0, `vpp_hi`=0, `id_hv`=0) the bus carries the stored byte at `addr`.
- R7: With `id_hv`=1 and every address bit other than bit 0 and bit ID_BIT (default 9) at 0, the bus carries 0xC2 when `addr[0]`=0 and 0x91 when `addr[0]`=1; `addr[ID_BIT]` is ignored.
- R8: Both identifier bytes have odd parity over all 8 bits, bit 7 acting as the parity bit.
- R9: With `id_hv`=1 and any other address bit (not bit 0, not bit ID_BIT) set, the bus carries 0xFF.
- R10: Counting the first edge of each condition as 1, `dout_en` rises with valid data at the first edge where chip enable has been low CE_CYC edges, output enable low OE_CYC edges and `addr`/`id_hv` unchanged ACC_CYC edges; an address change while selected drops `dout_en` until the address count is met again.
- R11: When read mode is left, `dout_en` stays high holding the last byte for DF_CYC edges and falls at the next one.
- R12: A bit once cleared never returns to 1, whatever later program data is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; sets the array to all ones |
| addr | input | AW | Byte address |
| ce_n | input | 1 | Active-low chip enable; a low pulse programs when `vpp_hi` is set |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Output-enable pin is at programming voltage |
| id_hv | input | 1 | Identify line is at its high voltage |
| din | input | 8 | Data to program |
| dout | output | 8 | Data bus value |
| dout_en | output | 1 | Bus drive enable (0 = high impedance) |

## Verification
The hardest situation to reach from the pins is a second write inside one long program pulse: the bench raises the programming flag, drops chip enable once with a data pattern, then changes the data to all zeros for several edges before releasing the pulse, and reads back to show only the first pattern was merged. Timing corners are reached by directed sequences that sample one edge before each expected rise, change the address while the bus is driven, and release chip enable while output enable stays low. Sticky zeros are shown by programming a byte twice with complementary and all-ones patterns from a vector table.

// File: rtl/otp_rom_pkg.sv
`timescale 1ns/1ps
package otp_rom_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_INHIBIT,
        MD_PROGRAM,
        MD_DISABLE,
        MD_READ,
        MD_IDENT
    } otp_mode_e;

    localparam logic [7:0] MFR_ID = 8'hC2;
    localparam logic [7:0] DEV_ID = 8'h91;
    localparam logic [7:0] ERASED = 8'hFF;

    function automatic logic odd_par(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
`timescale 1ns/1ps
module otp_mode_decode
    import otp_rom_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      vpp_hi,
    input  logic      id_hv,
    output otp_mode_e mode
);
    always_comb begin
        if (ce_n)
            mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
        else if (vpp_hi)
            mode = MD_PROGRAM;
        else if (oe_n)
            mode = MD_DISABLE;
        else if (id_hv)
            mode = MD_IDENT;
        else
            mode = MD_READ;
    end
endmodule

// File: rtl/otp_id_source.sv
`timescale 1ns/1ps
module otp_id_source
    import otp_rom_pkg::*;
#(
    parameter int AW     = 10,
    parameter int ID_BIT = 9
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    id_byte
);
    logic rest_clear;

    always_comb begin
        rest_clear = 1'b1;
        for (int i = 1; i < AW; i++) begin
            if (i != ID_BIT && addr[i])
                rest_clear = 1'b0;
        end
        if (!rest_clear)
            id_byte = ERASED;
        else
            id_byte = addr[0] ? DEV_ID : MFR_ID;
    end
endmodule

// File: rtl/otp_cell_array.sv
`timescale 1ns/1ps
module otp_cell_array #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_mask,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells_q[i] <= 8'hFF;
        end else if (wr_en) begin
            cells_q[wr_addr] <= cells_q[wr_addr] & wr_mask;
        end
    end

    assign rd_data = cells_q[rd_addr];
endmodule

// File: rtl/otp_rom.sv
`timescale 1ns/1ps
module otp_rom
    import otp_rom_pkg::*;
#(
    parameter int AW      = 10,
    parameter int ID_BIT  = 9,
    parameter int ACC_CYC = 3,
    parameter int CE_CYC  = 3,
    parameter int OE_CYC  = 2,
    parameter int DF_CYC  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          vpp_hi,
    input  logic          id_hv,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic          dout_en
);
    localparam int LIM_A = (ACC_CYC > CE_CYC) ? ACC_CYC : CE_CYC;
    localparam int LIM_B = (OE_CYC > DF_CYC) ? OE_CYC : DF_CYC;
    localparam int LIM   = (LIM_A > LIM_B) ? LIM_A : LIM_B;
    localparam int CNT_W = $clog2(LIM + 2);

    typedef struct packed {
        logic [CNT_W-1:0] ce_age;
        logic [CNT_W-1:0] oe_age;
        logic [CNT_W-1:0] ad_age;
        logic [CNT_W-1:0] flt;
        logic [AW-1:0]    ad_prev;
        logic             id_prev;
        logic             ce_prev;
        logic             en;
        logic [7:0]       data;
    } state_t;

    state_t    s_d, s_q;
    otp_mode_e mode;
    logic [7:0] id_byte;
    logic [7:0] cell_byte;
    logic       wr_en;
    logic       active;
    logic       ready;

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
        return (v >= CNT_W'(LIM)) ? v : v + 1'b1;
    endfunction

    otp_mode_decode u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .id_hv  (id_hv),
        .mode   (mode)
    );

    otp_id_source #(.AW(AW), .ID_BIT(ID_BIT)) u_ids (
        .addr    (addr),
        .id_byte (id_byte)
    );

    otp_cell_array #(.AW(AW)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wr_mask (din),
        .rd_addr (addr),
        .rd_data (cell_byte)
    );

    // one write per chip-enable pulse: only the edge that sees the fall
    assign wr_en  = (mode == MD_PROGRAM) && s_q.ce_prev;
    assign active = (mode == MD_READ) || (mode == MD_IDENT);

    always_comb begin
        s_d         = s_q;
        s_d.ce_prev = ce_n;
        s_d.ce_age  = ce_n ? '0 : bump(s_q.ce_age);
        s_d.oe_age  = (!oe_n && !vpp_hi) ? bump(s_q.oe_age) : '0;
        s_d.ad_prev = addr;
        s_d.id_prev = id_hv;
        if (addr != s_q.ad_prev || id_hv != s_q.id_prev)
            s_d.ad_age = CNT_W'(1);
        else
            s_d.ad_age = bump(s_q.ad_age);

        ready = (s_d.ce_age >= CNT_W'(CE_CYC)) &&
                (s_d.oe_age >= CNT_W'(OE_CYC)) &&
                (s_d.ad_age >= CNT_W'(ACC_CYC));

        if (active) begin
            s_d.flt = '0;
            s_d.en  = ready;
            if (ready)
                s_d.data = (mode == MD_IDENT) ? id_byte : cell_byte;
        end else if (s_q.en && (s_q.flt < CNT_W'(DF_CYC))) begin
            s_d.flt = s_q.flt + 1'b1;
            s_d.en  = 1'b1;
        end else begin
            s_d.flt = '0;
            s_d.en  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.ce_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout    = s_q.data;
    assign dout_en = s_q.en;
endmodule

// File: rtl/otp_rom_checks.sv
`timescale 1ns/1ps
module otp_rom_checks
    import otp_rom_pkg::*;
#(
    parameter int AW     = 10,
    parameter int ID_BIT = 9,
    parameter int DF_CYC = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          ce_n,
    input logic          oe_n,
    input logic          vpp_hi,
    input logic          id_hv,
    input logic [7:0]    dout,
    input logic          dout_en
);
    localparam int CW = $clog2(DF_CYC + 2) + 1;

    logic [CW-1:0] idle_cnt_q, ce_hi_cnt_q;
    logic          sel, rest_clear;

    assign sel = !ce_n && !oe_n && !vpp_hi;

    always_comb begin
        rest_clear = 1'b1;
        for (int i = 1; i < AW; i++) begin
            if (i != ID_BIT && addr[i])
                rest_clear = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt_q  <= '0;
            ce_hi_cnt_q <= '0;
        end else begin
            if (sel)
                idle_cnt_q <= '0;
            else if (idle_cnt_q <= CW'(DF_CYC))
                idle_cnt_q <= idle_cnt_q + 1'b1;
            if (!ce_n)
                ce_hi_cnt_q <= '0;
            else if (ce_hi_cnt_q <= CW'(DF_CYC))
                ce_hi_cnt_q <= ce_hi_cnt_q + 1'b1;
        end
    end

    p_drive_needs_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(sel));

    p_float_after_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt_q > CW'(DF_CYC)) |-> !dout_en);

    p_standby_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_hi_cnt_q > CW'(DF_CYC)) |-> !dout_en);

    p_id_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dout_en) && $past(sel && id_hv && rest_clear))
        |-> (dout == ($past(addr[0]) ? 8'h91 : 8'hC2)));

    p_id_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dout_en) && $past(sel && id_hv && rest_clear)) |-> odd_par(dout));

    p_id_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dout_en) && $past(sel && id_hv && !rest_clear)) |-> (dout == 8'hFF));
endmodule

bind otp_rom otp_rom_checks #(.AW(AW), .ID_BIT(ID_BIT), .DF_CYC(DF_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_hi  (vpp_hi),
    .id_hv   (id_hv),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/otp_rom_test.sv
`timescale 1ns/1ps
module otp_rom_test;
    localparam int AW      = 10;
    localparam int ACC_CYC = 3;
    localparam int CE_CYC  = 3;
    localparam int OE_CYC  = 2;
    localparam int DF_CYC  = 1;
    localparam int LAT_A   = (ACC_CYC > CE_CYC) ? ACC_CYC : CE_CYC;
    localparam int LAT     = (LAT_A > OE_CYC) ? LAT_A : OE_CYC;
    localparam logic [1:0] OP_PROG = 2'd0;
    localparam logic [1:0] OP_READ = 2'd1;

    // {op, id flag, addr, program data, expected byte}
    localparam logic [28:0] VEC [14] = '{
        {OP_READ, 1'b0, 10'h005, 8'h00, 8'hFF},  // R3 erased
        {OP_PROG, 1'b0, 10'h005, 8'hA5, 8'h00},  // R4
        {OP_READ, 1'b0, 10'h005, 8'h00, 8'hA5},  // R4 R6
        {OP_PROG, 1'b0, 10'h005, 8'h5A, 8'h00},  // R4
        {OP_READ, 1'b0, 10'h005, 8'h00, 8'h00},  // R12 A5 & 5A
        {OP_PROG, 1'b0, 10'h3FF, 8'hF0, 8'h00},
        {OP_READ, 1'b0, 10'h3FF, 8'h00, 8'hF0},  // R6
        {OP_PROG, 1'b0, 10'h3FF, 8'hFF, 8'h00},
        {OP_READ, 1'b0, 10'h3FF, 8'h00, 8'hF0},  // R12 ones do not return
        {OP_READ, 1'b1, 10'h000, 8'h00, 8'hC2},  // R7 manufacturer
        {OP_READ, 1'b1, 10'h001, 8'h00, 8'h91},  // R7 device
        {OP_READ, 1'b1, 10'h004, 8'h00, 8'hFF},  // R9 stray bit
        {OP_READ, 1'b1, 10'h201, 8'h00, 8'h91},  // R7 bit 9 ignored
        {OP_READ, 1'b0, 10'h010, 8'h00, 8'hFF}   // R3
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_n, oe_n, vpp_hi, id_hv;
    logic [7:0]    din;
    logic [7:0]    dout;
    logic          dout_en;

    int total = 0;
    int bad   = 0;

    otp_rom #(.AW(AW), .ID_BIT(9), .ACC_CYC(ACC_CYC), .CE_CYC(CE_CYC),
              .OE_CYC(OE_CYC), .DF_CYC(DF_CYC)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .vpp_hi  (vpp_hi),
        .id_hv   (id_hv),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    initial forever #2 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle_bus();
        ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; id_hv = 1'b0;
        repeat (DF_CYC + 2) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic idf,
                      output logic en, output logic [7:0] d);
        @(negedge clk);
        addr = a; id_hv = idf; ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0;
        repeat (LAT) @(negedge clk);
        en = dout_en;
        d  = dout;
        idle_bus();
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; din = v; vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk) ce_n = 1'b0;
        @(negedge clk) ce_n = 1'b1;
        @(negedge clk) vpp_hi = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic       en;
        logic [7:0] d;
        rst_n = 1'b0; addr = '0; ce_n = 1'b1; oe_n = 1'b1;
        vpp_hi = 1'b0; id_hv = 1'b0; din = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset bus enable", {7'd0, dout_en}, 8'h00);

        // vector table
        for (int i = 0; i < 14; i++) begin
            if (VEC[i][28:27] == OP_PROG) begin
                prog(VEC[i][25:16], VEC[i][15:8]);
            end else begin
                rd(VEC[i][25:16], VEC[i][26], en, d);
                chk(VEC[i][26] ? "R7 R9 ident enable" : "R6 read enable",
                    {7'd0, en}, 8'h01);
                chk(VEC[i][26] ? "R7 R9 ident data" : "R4 R6 R12 read data",
                    d, VEC[i][7:0]);
                if (VEC[i][26] && VEC[i][7:0] != 8'hFF)
                    chk("R8 ident odd parity", {7'd0, ^d}, 8'h01);
            end
        end

        // R10 latency and address change
        @(negedge clk);
        addr = 10'h005; ce_n = 1'b0; oe_n = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        chk("R10 one edge early", {7'd0, dout_en}, 8'h00);
        @(negedge clk);
        chk("R10 enable at count", {7'd0, dout_en}, 8'h01);
        chk("R10 data at count", dout, 8'h00);
        addr = 10'h3FF;
        @(negedge clk);
        chk("R10 address change drops", {7'd0, dout_en}, 8'h00);
        repeat (ACC_CYC - 1) @(negedge clk);
        chk("R10 new address enable", {7'd0, dout_en}, 8'h01);
        chk("R10 new address data", dout, 8'hF0);

        // R11 float hold, then R2 standby with oe low
        ce_n = 1'b1;
        repeat (DF_CYC) @(negedge clk);
        chk("R11 hold enable", {7'd0, dout_en}, 8'h01);
        chk("R11 hold data", dout, 8'hF0);
        @(negedge clk);
        chk("R11 float", {7'd0, dout_en}, 8'h00);
        repeat (4) @(negedge clk);
        chk("R2 standby oe low", {7'd0, dout_en}, 8'h00);

        // R5 inhibit
        addr = 10'h020; din = 8'h00; vpp_hi = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 inhibit no drive", {7'd0, dout_en}, 8'h00);
        vpp_hi = 1'b0;
        idle_bus();
        rd(10'h020, 1'b0, en, d);
        chk("R5 inhibited byte", d, 8'hFF);

        // R1 output disable
        @(negedge clk);
        addr = 10'h005; ce_n = 1'b0; oe_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 output disable", {7'd0, dout_en}, 8'h00);
        idle_bus();

        // R4 one write per pulse
        addr = 10'h030; din = 8'h0F; vpp_hi = 1'b1;
        @(negedge clk) ce_n = 1'b0;
        @(negedge clk) din = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 program no drive", {7'd0, dout_en}, 8'h00);
        ce_n = 1'b1;
        @(negedge clk) vpp_hi = 1'b0;
        idle_bus();
        rd(10'h030, 1'b0, en, d);
        chk("R4 single write per pulse", d, 8'h0F);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule